// File: doc/BRIEF.md
# LCD Enable-Strobe Command Sequencer

This block sits between a user request port and the transmit side of an SPI master that drives a character LCD through a serial-to-parallel slave. A request names an operation and a byte. The operation can be: write a character, issue a raw LCD instruction, or clear the screen. The sequencer turns each request into three 16-bit transmit words. These words raise, lower and raise again the LCD enable bit while the data and register-select bits stay fixed. The display latches on the single falling edge of enable, so each request gives exactly one latched command.

Words are offered one at a time on a valid/ready port. A word is held until the SPI master takes it. The SPI master may keep shifting whatever sits on the word port while its buffer is empty. For that reason, the word shown while no word is offered always has enable high, and no unwanted falling edge can reach the display.

After the third word, the block stays busy for a fixed number of system clocks so the LCD can finish the command. A clear-screen command gets a longer wait. Requests made while busy are dropped. Cursor handling and polling of the display busy flag are not part of this block.

Top module: `lcd_strobe_seq`

## Requirements
- R1: After reset, `busy` is 0, `tx_valid` is 0 and `tx_word` is 16'h0100.
- R2: Each word has this layout: bits 7:0 carry the command byte, bit 8 is the enable level, bit 10 is register-select (1 for a character, 0 for an instruction), and bits 15:11 and bit 9 (read/write) are 0.
- R3: Every accepted request produces exactly three handshaken words, with enable 1, then 0, then 1. Bits other than bit 8 are identical in all three.
- R4: `req_op` encodings: 2'b00 writes the character `req_byte` (register-select 1). 2'b01 and 2'b11 send `req_byte` as an instruction (register-select 0). 2'b10 is clear screen, which sends byte 8'h01 with register-select 0 whatever `req_byte` holds.
- R5: Once `tx_valid` is 1, it stays 1 and `tx_word` stays unchanged until a cycle with `tx_ready` 1. A word counts as transferred only on a clock edge where both are 1.
- R6: Whenever `tx_valid` is 0, `tx_word` bit 8 (enable) is 1.
- R7: After the edge that transfers the third word, `busy` stays 1 for exactly SETTLE_CYC clocks. After a clear-screen operation it stays 1 for exactly CLEAR_CYC clocks.
- R8: A request is accepted on an edge where `req_valid` is 1 and `busy` is 0. From the next cycle, `busy` and `tx_valid` are 1 and the first word is offered.
- R9: A request made while `busy` is 1 is ignored. It neither changes the words of the current operation nor starts another operation after `busy` falls.
- R10: `tx_valid` is 1 only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | Operation code (see R4) |
| req_byte | input | 8 | Character or instruction byte |
| busy | output | 1 | Operation in progress or settle delay running |
| tx_word | output | 16 | Word offered to the SPI transmit path |
| tx_valid | output | 1 | tx_word is a word to be transferred |
| tx_ready | input | 1 | SPI transmit buffer empty, word taken this edge |

## Verification
The bench builds the block with SETTLE_CYC = 5 and CLEAR_CYC = 12. With these values, both settle windows are counted to the exact cycle, and the difference between a normal and a clear-screen wait is visible after every operation. A randomly stalling `tx_ready` exercises word holding across many back-pressure patterns. Requests injected during the word phase and during the settle window show that busy-time requests leave no trace.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int EN_POS    = 8;
    localparam int RW_POS    = 9;
    localparam int RS_POS    = 10;
    localparam int FRAMES    = 3;
    localparam logic [BYTE_W-1:0] CLEAR_BYTE = 8'h01;

    typedef enum logic [1:0] {
        OP_CHAR  = 2'b00,
        OP_INSTR = 2'b01,
        OP_CLEAR = 2'b10,
        OP_ALT   = 2'b11
    } lcd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_SEND = 2'b01,
        ST_WAIT = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic              rs;
        logic              long_wait;
        logic [BYTE_W-1:0] data;
    } lcd_cmd_t;

    function automatic lcd_cmd_t decode_req(input lcd_op_e op, input logic [BYTE_W-1:0] b);
        lcd_cmd_t c;
        c.rs        = (op == OP_CHAR);
        c.long_wait = (op == OP_CLEAR);
        c.data      = (op == OP_CLEAR) ? CLEAR_BYTE : b;
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] make_word(input lcd_cmd_t c, input logic en);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[BYTE_W-1:0] = c.data;
        w[EN_POS]  = en;
        w[RW_POS]  = 1'b0;
        w[RS_POS]  = c.rs;
        return w;
    endfunction

endpackage

// File: rtl/lcd_cmd_latch.sv
module lcd_cmd_latch
    import lcd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [1:0]        op,
    input  logic [BYTE_W-1:0] byte_in,
    output lcd_cmd_t          cmd
);
    lcd_cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q <= decode_req(lcd_op_e'(op), byte_in);
        end
    end

    assign cmd = cmd_q;
endmodule

// File: rtl/lcd_settle_timer.sv
module lcd_settle_timer #(
    parameter int SHORT_CYC = 40,
    parameter int LONG_CYC  = 1600
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic long_sel,
    output logic expired
);
    localparam int MAX_CYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SHORT_INIT = CNT_W'(SHORT_CYC - 1);
    localparam logic [CNT_W-1:0] LONG_INIT  = CNT_W'(LONG_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= long_sel ? LONG_INIT : SHORT_INIT;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lcd_frame_fsm.sv
module lcd_frame_fsm
    import lcd_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic tx_ready,
    input  logic timer_expired,
    output logic accept,
    output logic timer_load,
    output logic busy,
    output logic tx_valid,
    output logic en_level
);
    localparam int IDX_W = $clog2(FRAMES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);
    localparam logic [IDX_W-1:0] LOW_IDX  = IDX_W'(1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             xfer;

    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign xfer       = (state_q == ST_SEND) && tx_ready;
    assign timer_load = xfer && (idx_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_SEND;
                    idx_d   = '0;
                end
            end
            ST_SEND: begin
                if (xfer) begin
                    if (idx_q == LAST_IDX) begin
                        state_d = ST_WAIT;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (timer_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign tx_valid = (state_q == ST_SEND);
    assign en_level = (idx_q != LOW_IDX);
endmodule

// File: rtl/lcd_strobe_seq.sv
module lcd_strobe_seq
    import lcd_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 40,
    parameter int CLEAR_CYC  = 1600
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_byte,
    output logic        busy,
    output logic [15:0] tx_word,
    output logic        tx_valid,
    input  logic        tx_ready
);
    logic     accept;
    logic     timer_load;
    logic     timer_expired;
    logic     en_level;
    lcd_cmd_t cmd;

    lcd_cmd_latch u_cmd (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .op      (req_op),
        .byte_in (req_byte),
        .cmd     (cmd)
    );

    lcd_frame_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .tx_ready      (tx_ready),
        .timer_expired (timer_expired),
        .accept        (accept),
        .timer_load    (timer_load),
        .busy          (busy),
        .tx_valid      (tx_valid),
        .en_level      (en_level)
    );

    lcd_settle_timer #(
        .SHORT_CYC (SETTLE_CYC),
        .LONG_CYC  (CLEAR_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .long_sel (cmd.long_wait),
        .expired  (timer_expired)
    );

    // Outside a transfer the held word keeps enable high.
    assign tx_word = make_word(cmd, tx_valid ? en_level : 1'b1);
endmodule

// File: rtl/lcd_strobe_seq_chk.sv
module lcd_strobe_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        busy,
    input logic [15:0] tx_word,
    input logic        tx_valid,
    input logic        tx_ready
);
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_word)));

    assert_idle_enable_R6: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |-> tx_word[8]);

    assert_valid_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy);

    assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (busy && tx_valid));

    assert_payload_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(tx_word[15:9]) && $stable(tx_word[7:0])));

    assert_zero_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_word[15:11] == 5'd0) && !tx_word[9]);
endmodule

bind lcd_strobe_seq lcd_strobe_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .tx_word   (tx_word),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready)
);

// File: tb/sim_lcd_strobe_seq.sv
`timescale 1ns/1ps
module sim_lcd_strobe_seq;
    localparam int SETTLE = 5;
    localparam int CLEARW = 12;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [7:0]  req_byte = 8'h00;
    logic        busy;
    logic [15:0] tx_word;
    logic        tx_valid;
    logic        tx_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lcd_strobe_seq #(.SETTLE_CYC(SETTLE), .CLEAR_CYC(CLEARW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_byte(req_byte), .busy(busy), .tx_word(tx_word),
        .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    function automatic logic [15:0] exp_word(input logic [1:0] op, input logic [7:0] b, input int k);
        logic [15:0] w;
        w = 16'h0000;
        w[10] = (op == 2'b00);
        w[8]  = (k != 1);
        w[7:0] = (op == 2'b10) ? 8'h01 : b;
        return w;
    endfunction

    function automatic int exp_delay(input logic [1:0] op);
        return (op == 2'b10) ? CLEARW : SETTLE;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
            finish_run();
        end
    end

    // One complete operation; poke_mode 1 injects a request during words, 2 during settle
    task automatic run_op(input logic [1:0] op, input logic [7:0] b, input int ready_pct, input int poke_mode);
        int k;
        int n;
        int guard;
        @(negedge clk);
        check(!busy, "R8 idle before request", busy, 0);
        req_op = op; req_byte = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && tx_valid, "R8 busy and valid after accept", {busy, tx_valid}, 2'b11);
        if (poke_mode == 1) begin
            req_valid = 1'b1; req_op = ~op; req_byte = ~b;
        end
        k = 0;
        guard = 0;
        while (k < 3 && guard < 2000) begin
            tx_ready = (($urandom % 100) < ready_pct);
            check(tx_valid, "R5 valid held until transfer", tx_valid, 1);
            if (tx_valid && tx_ready) begin
                if (k == 0) check(tx_word == exp_word(op, b, 0), "R3 R2 R4 first word", tx_word, exp_word(op, b, 0));
                if (k == 1) check(tx_word == exp_word(op, b, 1), "R3 R2 R4 enable-low word", tx_word, exp_word(op, b, 1));
                if (k == 2) check(tx_word == exp_word(op, b, 2), "R3 R2 R4 last word", tx_word, exp_word(op, b, 2));
                k++;
            end
            @(negedge clk);
            req_valid = 1'b0;
            guard++;
        end
        tx_ready = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            check(!tx_valid && tx_word[8], "R6 R3 no extra word, enable high", {tx_valid, tx_word[8]}, 2'b01);
            if (poke_mode == 2 && n == 1) begin
                req_valid = 1'b1; req_op = 2'b00; req_byte = 8'hA5;
            end else begin
                req_valid = 1'b0;
            end
            tx_ready = $urandom % 2;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        tx_ready = 1'b0;
        check(n == exp_delay(op), "R7 settle length", n, exp_delay(op));
        check(!tx_valid && tx_word[8], "R6 idle word keeps enable", tx_word, 16'h0100);
        if (poke_mode != 0) begin
            @(negedge clk);
            check(!busy && !tx_valid, "R9 busy-time request ignored", {busy, tx_valid}, 2'b00);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !tx_valid && tx_word == 16'h0100, "R1 reset state", {busy, tx_valid, tx_word}, 18'h00100);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !tx_valid && tx_word == 16'h0100, "R1 after reset release", tx_word, 16'h0100);
        check(tx_word[8], "R6 idle after reset", tx_word, 16'h0100);

        // Directed corners
        run_op(2'b10, 8'h5A, 100, 0);   // R4 clear ignores byte, long wait (R7)
        run_op(2'b00, 8'h41, 100, 0);   // R4 character
        run_op(2'b01, 8'h0C, 30, 0);    // R4 instruction under stalls (R5)
        run_op(2'b11, 8'h80, 50, 0);    // R4 alternate instruction code
        run_op(2'b00, 8'hFF, 60, 1);    // R9 poke during words
        run_op(2'b10, 8'h00, 60, 2);    // R9 poke during clear settle
        run_op(2'b00, 8'h00, 10, 0);    // R5 heavy back-pressure

        for (int i = 0; i < 60; i++) begin
            run_op(2'($urandom % 4), 8'($urandom), 20 + ($urandom % 81), int'($urandom % 3));
        end
        finish_run();
    end
endmodule